// File: doc/BRIEF.md
# Configurable Parallel I/O Port

A general-purpose parallel port that sits on a simple synchronous register bus. It has a build-time width of 1 to 32 bits. Software picks the direction of each bit and drives values onto the output bits. It reads back the pin levels after synchronization and enables interrupt sources bit by bit. A sticky capture register records edges seen on the pins, and a write to it clears them.

The pad side is modelled as three vectors: sampled input levels, output values, and per-bit output enables that would drive a tri-state pad. Build-time parameters set the interrupt style and the kind of edge that capture records. The interrupt style is high level, low level, or captured edge. The edge kind is rising, falling, or either. Capture works the same way whichever interrupt style is chosen.

Top module: `gpio_port`

## Requirements
- R1: After reset the port has all bits as inputs (pin_oe zero), pin_out zero, the interrupt mask zero, all capture bits clear, irq low and bus_rdata zero.
- R2: A write with bus_cs and bus_wr high at bus_addr 0 updates pin_out to bus_wdata[WIDTH-1:0] at that clock edge.
- R3: A write at bus_addr 1 sets the direction bits, where 1 means output. pin_oe follows them from the next edge, and a read at bus_addr 1 returns them.
- R4: A write at bus_addr 2 sets the interrupt mask, where 1 enables that bit. A read at bus_addr 2 returns it.
- R5: A read (bus_cs and bus_rd high) loads bus_rdata at that clock edge, and bus_rdata holds its value in every other cycle. Bits at WIDTH and above always read as zero. Address 0 reads the pin levels after a two-flop synchronizer.
- R6: A bus cycle with bus_cs low changes no register and no output.
- R7: A capture bit is set by a synchronized edge of the configured kind (rising, falling or either) on its pin. It stays set until cleared and is read at bus_addr 3. This holds in every interrupt style.
- R8: A write of any value at bus_addr 3 clears every capture bit.
- R9: In edge interrupt style, irq is the OR over all bits of (capture AND mask).
- R10: In level style, irq is the OR over all bits of (synchronized level AND mask) for high level, or of (inverted synchronized level AND mask) for low level.
- R11: irq stays low while the mask is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_cs | input | 1 | Chip select |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register select: 0 pins, 1 direction, 2 mask, 3 capture |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | WIDTH | Pad input levels |
| pin_out | output | WIDTH | Output values toward the pad |
| pin_oe | output | WIDTH | Per-bit output enable, 1 means drive |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench builds three 8-bit ports on one shared bus and one shared pin vector. The first is edge style with either-edge capture, the second edge style with falling-edge capture, and the third low-level style with rising-edge capture. Every pin change therefore checks all three edge kinds at once. It also checks two of the three interrupt styles, and it shows that capture does not depend on the interrupt style. The 8-bit width leaves 24 upper read bits that must stay zero on every read.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int BUS_W = 32;

    typedef enum logic [1:0] {
        IRQ_LEVEL_HIGH = 2'd0,
        IRQ_LEVEL_LOW  = 2'd1,
        IRQ_EDGE       = 2'd2
    } irq_mode_e;

    typedef enum logic [1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_ANY  = 2'd2
    } edge_kind_e;

    localparam logic [1:0] REG_PINS = 2'd0;
    localparam logic [1:0] REG_DIR  = 2'd1;
    localparam logic [1:0] REG_MASK = 2'd2;
    localparam logic [1:0] REG_CAPT = 2'd3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge
    import gpio_pkg::*;
#(
    parameter int         WIDTH     = 32,
    parameter edge_kind_e EDGE_KIND = EDGE_RISE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    input  logic             clr,
    output logic [WIDTH-1:0] cap
);
    typedef struct packed {
        logic [WIDTH-1:0] prev;
        logic [WIDTH-1:0] cap;
    } edge_st_t;

    edge_st_t         st_d, st_q;
    logic [WIDTH-1:0] hit;

    generate
        if (EDGE_KIND == EDGE_RISE) begin : g_rise
            assign hit = lvl & ~st_q.prev;
        end else if (EDGE_KIND == EDGE_FALL) begin : g_fall
            assign hit = ~lvl & st_q.prev;
        end else begin : g_any
            assign hit = lvl ^ st_q.prev;
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl;
        // an edge arriving with the clear is kept
        st_d.cap  = (clr ? '0 : st_q.cap) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap = st_q.cap;

    // R7
    cap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((cap & $past(cap)) == $past(cap)));

    // R7
    cap_catches_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((cap & $past(hit)) == $past(hit)));

    // R8
    cap_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && hit == '0) |=> (cap == '0));
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq
    import gpio_pkg::*;
#(
    parameter int        WIDTH    = 32,
    parameter irq_mode_e IRQ_MODE = IRQ_EDGE
) (
    input  logic [WIDTH-1:0] lvl,
    input  logic [WIDTH-1:0] cap,
    input  logic [WIDTH-1:0] mask,
    output logic             irq
);
    logic [WIDTH-1:0] src;

    generate
        if (IRQ_MODE == IRQ_EDGE) begin : g_edge
            assign src = cap;
        end else if (IRQ_MODE == IRQ_LEVEL_HIGH) begin : g_high
            assign src = lvl;
        end else begin : g_low
            assign src = ~lvl;
        end
    endgenerate

    always_comb begin
        irq = |(src & mask);
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int         WIDTH     = 32,
    parameter irq_mode_e  IRQ_MODE  = IRQ_EDGE,
    parameter edge_kind_e EDGE_KIND = EDGE_RISE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_cs,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic             irq
);
    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic [WIDTH-1:0] dout;
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] mask;
        logic [BUS_W-1:0] rdata;
    } regs_t;

    regs_t            regs_d, regs_q;
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] cap;
    logic [WIDTH-1:0] wr_val;
    logic [BUS_W-1:0] rd_mux;
    logic             wr_hit, rd_hit, cap_clr;

    initial begin
        // R5
        width_range_chk: assert (WIDTH >= 1 && WIDTH <= BUS_W);
    end

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(pin_sync)
    );

    gpio_edge #(.WIDTH(WIDTH), .EDGE_KIND(EDGE_KIND)) edge_i (
        .clk(clk), .rst_n(rst_n), .lvl(pin_sync), .clr(cap_clr), .cap(cap)
    );

    gpio_irq #(.WIDTH(WIDTH), .IRQ_MODE(IRQ_MODE)) irq_i (
        .lvl(pin_sync), .cap(cap), .mask(regs_q.mask), .irq(irq)
    );

    assign wr_hit  = bus_cs & bus_wr;
    assign rd_hit  = bus_cs & bus_rd;
    assign cap_clr = wr_hit && (bus_addr == REG_CAPT);
    assign wr_val  = bus_wdata[WIDTH-1:0];

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            REG_PINS: rd_mux[WIDTH-1:0] = pin_sync;
            REG_DIR:  rd_mux[WIDTH-1:0] = regs_q.dir;
            REG_MASK: rd_mux[WIDTH-1:0] = regs_q.mask;
            default:  rd_mux[WIDTH-1:0] = cap;
        endcase
    end

    always_comb begin
        regs_d = regs_q;
        if (wr_hit) begin
            case (bus_addr)
                REG_PINS: regs_d.dout = wr_val;
                REG_DIR:  regs_d.dir  = wr_val;
                REG_MASK: regs_d.mask = wr_val;
                default:  ;
            endcase
        end
        if (rd_hit) regs_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign bus_rdata = regs_q.rdata;
    assign pin_out   = regs_q.dout;
    assign pin_oe    = regs_q.dir;

    // R3
    oe_follows_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && bus_wr && bus_addr == REG_DIR) |=> (pin_oe == $past(bus_wdata[WIDTH-1:0])));

    // R2
    out_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cs && bus_wr && bus_addr == REG_PINS) |=> (pin_out == $past(bus_wdata[WIDTH-1:0])));

    // R6
    no_select_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cs |=> ($stable(pin_out) && $stable(pin_oe) && $stable(bus_rdata)));

    // R5
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_cs && bus_rd) |=> $stable(bus_rdata));

    // R11
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.mask == '0) |-> !irq);
endmodule

// File: tb/gpio_port_tb_top.sv
`timescale 1ns/1ps
module gpio_port_tb_top;
    import gpio_pkg::*;
    localparam int W = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, cs, rd, wr;
    logic [1:0]  addr;
    logic [31:0] wdata;
    logic [W-1:0] pins;

    logic [31:0]  rd_e, rd_f, rd_l;
    logic [W-1:0] out_e, out_f, out_l, oe_e, oe_f, oe_l;
    logic         irq_e, irq_f, irq_l;

    gpio_port #(.WIDTH(W), .IRQ_MODE(IRQ_EDGE), .EDGE_KIND(EDGE_ANY)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_cs(cs), .bus_rd(rd), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rd_e), .pin_in(pins), .pin_out(out_e), .pin_oe(oe_e), .irq(irq_e));
    gpio_port #(.WIDTH(W), .IRQ_MODE(IRQ_EDGE), .EDGE_KIND(EDGE_FALL)) dut_f_i (
        .clk(clk), .rst_n(rst_n), .bus_cs(cs), .bus_rd(rd), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rd_f), .pin_in(pins), .pin_out(out_f), .pin_oe(oe_f), .irq(irq_f));
    gpio_port #(.WIDTH(W), .IRQ_MODE(IRQ_LEVEL_LOW), .EDGE_KIND(EDGE_RISE)) dut_l_i (
        .clk(clk), .rst_n(rst_n), .bus_cs(cs), .bus_rd(rd), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rd_l), .pin_in(pins), .pin_out(out_l), .pin_oe(oe_l), .irq(irq_l));

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [W-1:0] m_dout, m_dir, m_mask, m_pins, m_cap_any, m_cap_fall, m_cap_rise;

    function automatic logic [31:0] ext(input logic [W-1:0] v);
        logic [31:0] r;
        r = '0;
        r[W-1:0] = v;
        return r;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
        case (a)
            REG_PINS: m_dout = d[W-1:0];
            REG_DIR:  m_dir  = d[W-1:0];
            REG_MASK: m_mask = d[W-1:0];
            default: begin m_cap_any = '0; m_cap_fall = '0; m_cap_rise = '0; end
        endcase
    endtask

    task automatic bus_read(input logic [1:0] a);
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; addr = a;
        @(negedge clk);
        cs = 1'b0; rd = 1'b0;
    endtask

    task automatic set_pins(input logic [W-1:0] v);
        @(negedge clk);
        pins = v;
        m_cap_any  |= (v ^ m_pins);
        m_cap_fall |= (~v & m_pins);
        m_cap_rise |= (v & ~m_pins);
        m_pins = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic verify(input string tag);
        bus_read(REG_PINS);
        chk("R5", {tag, " pins edge"}, rd_e, ext(m_pins));
        chk("R5", {tag, " pins fall"}, rd_f, ext(m_pins));
        chk("R5", {tag, " pins lvl"},  rd_l, ext(m_pins));
        bus_read(REG_DIR);
        chk("R3", {tag, " dir"}, rd_e, ext(m_dir));
        chk("R3", {tag, " dir lvl"}, rd_l, ext(m_dir));
        bus_read(REG_MASK);
        chk("R4", {tag, " mask"}, rd_f, ext(m_mask));
        bus_read(REG_CAPT);
        chk("R7", {tag, " cap any"},  rd_e, ext(m_cap_any));
        chk("R7", {tag, " cap fall"}, rd_f, ext(m_cap_fall));
        chk("R7", {tag, " cap rise"}, rd_l, ext(m_cap_rise));
        chk("R2", {tag, " pin_out"}, ext(out_e), ext(m_dout));
        chk("R2", {tag, " pin_out lvl"}, ext(out_l), ext(m_dout));
        chk("R3", {tag, " pin_oe"}, ext(oe_f), ext(m_dir));
        chk("R9", {tag, " irq any"},  {31'b0, irq_e}, {31'b0, |(m_cap_any & m_mask)});
        chk("R9", {tag, " irq fall"}, {31'b0, irq_f}, {31'b0, |(m_cap_fall & m_mask)});
        chk("R10", {tag, " irq low"}, {31'b0, irq_l}, {31'b0, |(~m_pins & m_mask)});
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; cs = 1'b0; rd = 1'b0; wr = 1'b0; addr = '0; wdata = '0; pins = '0;
        m_dout = '0; m_dir = '0; m_mask = '0; m_pins = '0;
        m_cap_any = '0; m_cap_fall = '0; m_cap_rise = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "oe", ext(oe_e), '0);
        chk("R1", "out", ext(out_e), '0);
        chk("R1", "rdata", rd_e, '0);
        chk("R1", "irq", {31'b0, irq_e | irq_f}, '0);
        verify("R1 reset");

        // R6 unselected write and read are ignored
        @(negedge clk);
        cs = 1'b0; wr = 1'b1; rd = 1'b1; addr = REG_DIR; wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        wr = 1'b0; rd = 1'b0;
        chk("R6", "oe after unselected write", ext(oe_e), '0);
        chk("R6", "rdata after unselected read", rd_e, '0);
        verify("R6");

        // R11 edges captured but mask zero
        set_pins(8'h0F);
        chk("R11", "irq with zero mask", {31'b0, irq_e}, '0);
        verify("R7 rise");
        set_pins(8'h05);
        verify("R7 fall");
        bus_write(REG_MASK, 32'hFFFF_FF0A);
        verify("R9 mask");
        bus_write(REG_CAPT, 32'h0);
        chk("R8", "irq after clear", {31'b0, irq_e}, '0);
        verify("R8 clear");
        bus_write(REG_DIR, 32'hDEAD_BEA5);
        bus_write(REG_PINS, 32'h1234_5678);
        set_pins(8'hFF);
        verify("R10 all high");

        for (int it = 0; it < 300; it++) begin
            int op;
            op = int'($urandom % 5);
            case (op)
                0: bus_write(REG_PINS, $urandom);
                1: bus_write(REG_DIR,  $urandom);
                2: bus_write(REG_MASK, $urandom);
                3: bus_write(REG_CAPT, $urandom);
                default: set_pins(W'($urandom));
            endcase
            verify("rand");
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule